// File: doc/BRIEF.md
# Supervisor State-Restore Header Checker

This block decides whether a privileged restore of extended processor state may go ahead, and if so, which state components are loaded from memory and which are put back to their reset values. A single-cycle `start` pulse presents the 64-bit instruction mask, the user-state and supervisor-state enable registers, the current privilege level, the control and feature-support bits, the four prefix flags and the base address of the save area. The block first screens the instruction for faults that need no memory access. If none applies, it reads the 64-byte save-area header as eight 64-bit words and checks the header fields against each other and against the user-state enable register.

On any fault the block ends the instruction with one fault code and issues no per-component strobes. Otherwise it walks component indices upward from 0, one index per cycle, over `NCOMP` components. For each component whose requested-mask bit is set, it asserts `comp_load` when the header's restore bitmap has that bit set, and `comp_init` when the bit is clear. The requested mask is the instruction mask ANDed with the OR of the two enable registers. Every accepted instruction ends with a one-cycle `done` pulse.

The header read port is valid/ready on both channels. A request stays asserted with a stable address until `rd_req_ready` accepts it, and only one request is outstanding at a time. The response is consumed only in a cycle where `rd_rsp_ready` and `rd_rsp_valid` are both high. Either side may stall for any number of cycles. All other pins are plain levels or pulses.

Top module: `prs_restore_seq`

## Requirements
- R1: Faults take a fixed priority: undefined-opcode (code 1), then device-not-available (code 2), then the privilege and alignment general-protection checks (code 3), then the header checks (code 3). When any of the first three applies, `rd_req_valid` never rises for that instruction.
- R2: Code 1 is reported when `feat_xsave`, `feat_sup` or `os_xsave_en` is 0, or when any of `pfx_lock`, `pfx_opsz`, `pfx_rep`, `pfx_repne` is 1. It appears on `fault_code` in the cycle after the accepting edge, together with `done`.
- R3: With no code-1 cause present, `task_sw` = 1 gives code 2 in the cycle after the accepting edge.
- R4: With no earlier cause present, `priv_lvl` not equal to 0 or `area_addr[5:0]` not equal to 0 gives code 3 in the cycle after the accepting edge.
- R5: The header is read as exactly eight requests at addresses base+0, base+8, ... base+56, in that order. A request holds `rd_req_valid` and `rd_req_addr` until it is accepted. Word 0 is the restore bitmap and word 1 is the compaction bitmap.
- R6: Compaction-bitmap bit 63 equal to 0 gives code 3.
- R7: Any compaction-bitmap bit in positions 62..0 that is 1 while the same bit of `user_en` is 0 gives code 3.
- R8: Any restore-bitmap bit that is 1 while the same compaction-bitmap bit is 0 gives code 3.
- R9: Any non-zero bit in header words 2 through 7 gives code 3.
- R10: With no fault, components 0..NCOMP-1 are visited in ascending order, at most one strobe per cycle. Component i gets `comp_load` if requested-mask bit i and restore-bitmap bit i are both 1, gets `comp_init` if requested-mask bit i is 1 and the restore bit is 0, and gets no strobe otherwise. `comp_idx` names the component.
- R11: Each accepted instruction produces exactly one one-cycle `done` pulse. `fault_valid` is high with it only on a fault, and `fault_code` is 0 on success. No strobe is issued on a faulting instruction.
- R12: A `start` pulse while `busy` is high is ignored. The running instruction's result and strobes are unchanged, and no second `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Accept a new instruction when idle |
| instr_mask | input | 64 | Instruction-supplied component mask |
| user_en | input | 64 | User-state enable register |
| sup_en | input | 64 | Supervisor-state enable register |
| priv_lvl | input | 2 | Current privilege level |
| os_xsave_en | input | 1 | OS has enabled extended-state management |
| task_sw | input | 1 | Task-switched control bit |
| feat_xsave | input | 1 | Extended save/restore is supported |
| feat_sup | input | 1 | Supervisor-state save/restore is supported |
| pfx_lock | input | 1 | LOCK prefix present |
| pfx_opsz | input | 1 | 66H prefix present |
| pfx_rep | input | 1 | F3H prefix present |
| pfx_repne | input | 1 | F2H prefix present |
| area_addr | input | ADDR_W | Save-area base address |
| rd_req_valid | output | 1 | Header read request valid |
| rd_req_ready | input | 1 | Header read request accepted |
| rd_req_addr | output | ADDR_W | Byte address of the requested header word |
| rd_rsp_valid | input | 1 | Header read data valid |
| rd_rsp_ready | output | 1 | Block can take read data |
| rd_rsp_data | input | 64 | Header read data |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | One-cycle end-of-instruction pulse |
| fault_valid | output | 1 | The finishing instruction faulted |
| fault_code | output | 2 | 0 none, 1 undefined-opcode, 2 device-not-available, 3 general-protection |
| comp_load | output | 1 | Load component `comp_idx` from memory |
| comp_init | output | 1 | Initialize component `comp_idx` |
| comp_idx | output | $clog2(NCOMP) | Component index for the strobes |

## Verification
The bound checker checks the properties that hold every cycle. It confirms that a stalled header request keeps its address, that `done` lasts a single cycle, that strobes never overlap each other or `done`, that back-to-back strobes step the index by one, and that no read request appears while idle. It also checks the fault code that follows a start carrying an undefined-opcode, device-not-available or privilege/alignment cause. Some behaviour only the bench's sweeps can show: the exact set of loaded and initialized components under many bitmap combinations, the header cross-field rules, the request address sequence under random stalls, and that an ignored second start leaves the running result unchanged.

// File: rtl/prs_pkg.sv
package prs_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_UD   = 2'd1,
    FLT_NM   = 2'd2,
    FLT_GP   = 2'd3
  } fault_e;

  typedef enum logic [2:0] {
    CT_IDLE,
    CT_FETCH,
    CT_CHECK,
    CT_WALK,
    CT_FIN
  } ctl_e;

  localparam int unsigned HDR_WORDS = 8;
  localparam int unsigned WORD_W    = 64;
  localparam int unsigned WORD_LSB  = 3;   // byte offset bits of one word
  localparam int unsigned ALIGN_W   = 6;   // 64-byte alignment
  localparam int unsigned FMT_BIT   = 63;  // compaction format flag
endpackage

// File: rtl/prs_precheck.sv
module prs_precheck
  import prs_pkg::*;
(
  input  logic               feat_xsave,
  input  logic               feat_sup,
  input  logic               os_xsave_en,
  input  logic [3:0]         pfx_any,
  input  logic               task_sw,
  input  logic [1:0]         priv_lvl,
  input  logic [ALIGN_W-1:0] addr_lo,
  output fault_e             code
);
  logic ud_hit, nm_hit, gp_hit;

  assign ud_hit = !feat_xsave || !feat_sup || !os_xsave_en || (|pfx_any);
  assign nm_hit = task_sw;
  assign gp_hit = (priv_lvl != 2'd0) || (addr_lo != '0);

  always_comb begin
    if (ud_hit)      code = FLT_UD;
    else if (nm_hit) code = FLT_NM;
    else if (gp_hit) code = FLT_GP;
    else             code = FLT_NONE;
  end
endmodule

// File: rtl/prs_hdr_fetch.sv
module prs_hdr_fetch
  import prs_pkg::*;
#(
  parameter int unsigned ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] base,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [WORD_W-1:0] rsp_data,
  output logic [WORD_W-1:0] restore_q,
  output logic [WORD_W-1:0] compact_q,
  output logic              tail_nz_q,
  output logic              fetch_done
);
  localparam int unsigned CNT_W = $clog2(HDR_WORDS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HDR_WORDS - 1);

  typedef enum logic [1:0] {FS_IDLE, FS_REQ, FS_RSP} fs_e;

  fs_e             fs;
  logic [CNT_W-1:0] cnt;

  assign req_valid  = (fs == FS_REQ);
  assign rsp_ready  = (fs == FS_RSP);
  assign req_addr   = base + ADDR_W'({cnt, {WORD_LSB{1'b0}}});
  assign fetch_done = (fs == FS_RSP) && rsp_valid && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs        <= FS_IDLE;
      cnt       <= '0;
      restore_q <= '0;
      compact_q <= '0;
      tail_nz_q <= 1'b0;
    end else begin
      case (fs)
        FS_IDLE: if (go) begin
          fs        <= FS_REQ;
          cnt       <= '0;
          tail_nz_q <= 1'b0;
        end
        FS_REQ: if (req_ready) fs <= FS_RSP;
        FS_RSP: if (rsp_valid) begin
          case (cnt)
            CNT_W'(0): restore_q <= rsp_data;
            CNT_W'(1): compact_q <= rsp_data;
            default:   tail_nz_q <= tail_nz_q | (|rsp_data);
          endcase
          if (cnt == LAST) begin
            fs <= FS_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
            fs  <= FS_REQ;
          end
        end
        default: fs <= FS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/prs_hdr_rules.sv
module prs_hdr_rules
  import prs_pkg::*;
(
  input  logic [WORD_W-1:0] restore_bm,
  input  logic [WORD_W-1:0] compact_bm,
  input  logic              tail_nz,
  input  logic [WORD_W-1:0] user_en,
  output logic              gp
);
  logic fmt_bad, comp_bad, rest_bad;

  assign fmt_bad  = !compact_bm[FMT_BIT];
  assign comp_bad = |(compact_bm[FMT_BIT-1:0] & ~user_en[FMT_BIT-1:0]);
  assign rest_bad = |(restore_bm & ~compact_bm);
  assign gp       = fmt_bad || comp_bad || rest_bad || tail_nz;

  logic unused_en_top;
  assign unused_en_top = user_en[FMT_BIT];
endmodule

// File: rtl/prs_comp_walk.sv
module prs_comp_walk #(
  parameter int unsigned NCOMP = 8,
  localparam int unsigned IDX_W = (NCOMP > 1) ? $clog2(NCOMP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NCOMP-1:0] rfbm,
  input  logic [NCOMP-1:0] rstor,
  output logic             load,
  output logic             init,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  logic             active;
  logic [IDX_W-1:0] idx_q;
  logic [NCOMP-1:0] ld_vec, in_vec;

  for (genvar g = 0; g < NCOMP; g++) begin : g_sel
    assign ld_vec[g] = rfbm[g] &  rstor[g];
    assign in_vec[g] = rfbm[g] & ~rstor[g];
  end

  assign idx  = idx_q;
  assign load = active && ld_vec[idx_q];
  assign init = active && in_vec[idx_q];
  assign last = active && (idx_q == IDX_W'(NCOMP - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx_q  <= '0;
    end else if (go) begin
      active <= 1'b1;
      idx_q  <= '0;
    end else if (active) begin
      if (last) active <= 1'b0;
      else      idx_q  <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/prs_restore_seq.sv
module prs_restore_seq
  import prs_pkg::*;
#(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned NCOMP  = 8,
  localparam int unsigned IDX_W = (NCOMP > 1) ? $clog2(NCOMP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [63:0]       instr_mask,
  input  logic [63:0]       user_en,
  input  logic [63:0]       sup_en,
  input  logic [1:0]        priv_lvl,
  input  logic              os_xsave_en,
  input  logic              task_sw,
  input  logic              feat_xsave,
  input  logic              feat_sup,
  input  logic              pfx_lock,
  input  logic              pfx_opsz,
  input  logic              pfx_rep,
  input  logic              pfx_repne,
  input  logic [ADDR_W-1:0] area_addr,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [63:0]       rd_rsp_data,
  output logic              busy,
  output logic              done,
  output logic              fault_valid,
  output logic [1:0]        fault_code,
  output logic              comp_load,
  output logic              comp_init,
  output logic [IDX_W-1:0]  comp_idx
);
  ctl_e              st;
  fault_e            flt_q, pre_code;
  logic [NCOMP-1:0]  rfbm_q;
  logic [63:0]       user_q;
  logic [ADDR_W-1:0] base_q;
  logic [63:0]       restore_bm, compact_bm;
  logic              tail_nz, fetch_done, hdr_gp, walk_last;
  logic              accept, fetch_go, walk_go;
  logic [NCOMP-1:0]  rfbm_now;

  assign rfbm_now = (user_en[NCOMP-1:0] | sup_en[NCOMP-1:0]) & instr_mask[NCOMP-1:0];

  prs_precheck u_pre (
    .feat_xsave  (feat_xsave),
    .feat_sup    (feat_sup),
    .os_xsave_en (os_xsave_en),
    .pfx_any     ({pfx_lock, pfx_opsz, pfx_rep, pfx_repne}),
    .task_sw     (task_sw),
    .priv_lvl    (priv_lvl),
    .addr_lo     (area_addr[ALIGN_W-1:0]),
    .code        (pre_code)
  );

  assign accept   = (st == CT_IDLE) && start;
  assign fetch_go = accept && (pre_code == FLT_NONE);
  assign walk_go  = (st == CT_CHECK) && !hdr_gp;

  prs_hdr_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (fetch_go),
    .base       (base_q),
    .req_valid  (rd_req_valid),
    .req_ready  (rd_req_ready),
    .req_addr   (rd_req_addr),
    .rsp_valid  (rd_rsp_valid),
    .rsp_ready  (rd_rsp_ready),
    .rsp_data   (rd_rsp_data),
    .restore_q  (restore_bm),
    .compact_q  (compact_bm),
    .tail_nz_q  (tail_nz),
    .fetch_done (fetch_done)
  );

  prs_hdr_rules u_rules (
    .restore_bm (restore_bm),
    .compact_bm (compact_bm),
    .tail_nz    (tail_nz),
    .user_en    (user_q),
    .gp         (hdr_gp)
  );

  prs_comp_walk #(.NCOMP(NCOMP)) u_walk (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (walk_go),
    .rfbm  (rfbm_q),
    .rstor (restore_bm[NCOMP-1:0]),
    .load  (comp_load),
    .init  (comp_init),
    .idx   (comp_idx),
    .last  (walk_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= CT_IDLE;
      flt_q  <= FLT_NONE;
      rfbm_q <= '0;
      user_q <= '0;
      base_q <= '0;
    end else begin
      case (st)
        CT_IDLE: if (start) begin
          rfbm_q <= rfbm_now;
          user_q <= user_en;
          base_q <= area_addr;
          flt_q  <= pre_code;
          st     <= (pre_code == FLT_NONE) ? CT_FETCH : CT_FIN;
        end
        CT_FETCH: if (fetch_done) st <= CT_CHECK;
        CT_CHECK: begin
          flt_q <= hdr_gp ? FLT_GP : FLT_NONE;
          st    <= hdr_gp ? CT_FIN : CT_WALK;
        end
        CT_WALK:  if (walk_last) st <= CT_FIN;
        CT_FIN:   st <= CT_IDLE;
        default:  st <= CT_IDLE;
      endcase
    end
  end

  assign busy        = (st != CT_IDLE);
  assign done        = (st == CT_FIN);
  assign fault_valid = done && (flt_q != FLT_NONE);
  assign fault_code  = done ? flt_q : FLT_NONE;

  logic unused_hi;
  assign unused_hi = ^{instr_mask[63:NCOMP], sup_en[63:NCOMP], accept};
endmodule

// File: rtl/prs_restore_seq_chk.sv
module prs_restore_seq_chk #(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned NCOMP  = 8,
  localparam int unsigned IDX_W = (NCOMP > 1) ? $clog2(NCOMP) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [1:0]        priv_lvl,
  input logic              os_xsave_en,
  input logic              task_sw,
  input logic              feat_xsave,
  input logic              feat_sup,
  input logic              pfx_lock,
  input logic              pfx_opsz,
  input logic              pfx_rep,
  input logic              pfx_repne,
  input logic [ADDR_W-1:0] area_addr,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              busy,
  input logic              done,
  input logic [1:0]        fault_code,
  input logic              comp_load,
  input logic              comp_init,
  input logic [IDX_W-1:0]  comp_idx
);
  logic ud_cause, pre_gp;
  assign ud_cause = !feat_xsave || !feat_sup || !os_xsave_en ||
                    pfx_lock || pfx_opsz || pfx_rep || pfx_repne;
  assign pre_gp   = (priv_lvl != 2'd0) || (area_addr[5:0] != 6'd0);

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  strobe_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_load || comp_init) |-> !done);

  // R10
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({comp_load, comp_init}));

  // R10
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_load || comp_init) && $past(comp_load || comp_init)
      |-> comp_idx == IDX_W'($past(comp_idx) + 1'b1));

  // R1
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> busy);

  // R2
  ud_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && ud_cause |=> done && fault_code == 2'd1);

  // R3
  nm_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !ud_cause && task_sw |=> done && fault_code == 2'd2);

  // R4
  gp_pre_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !ud_cause && !task_sw && pre_gp |=> done && fault_code == 2'd3);
endmodule

bind prs_restore_seq prs_restore_seq_chk #(.ADDR_W(ADDR_W), .NCOMP(NCOMP)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .priv_lvl     (priv_lvl),
  .os_xsave_en  (os_xsave_en),
  .task_sw      (task_sw),
  .feat_xsave   (feat_xsave),
  .feat_sup     (feat_sup),
  .pfx_lock     (pfx_lock),
  .pfx_opsz     (pfx_opsz),
  .pfx_rep      (pfx_rep),
  .pfx_repne    (pfx_repne),
  .area_addr    (area_addr),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_req_addr  (rd_req_addr),
  .busy         (busy),
  .done         (done),
  .fault_code   (fault_code),
  .comp_load    (comp_load),
  .comp_init    (comp_init),
  .comp_idx     (comp_idx)
);

// File: tb/prs_restore_seq_tb.sv
module prs_restore_seq_tb;
  localparam int ADDR_W = 48;
  localparam int NCOMP  = 8;
  localparam int IDX_W  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [63:0] instr_mask = '0, user_en = '0, sup_en = '0;
  logic [1:0] priv_lvl = '0;
  logic os_xsave_en = 1'b0, task_sw = 1'b0, feat_xsave = 1'b0, feat_sup = 1'b0;
  logic pfx_lock = 1'b0, pfx_opsz = 1'b0, pfx_rep = 1'b0, pfx_repne = 1'b0;
  logic [ADDR_W-1:0] area_addr = '0;
  logic rd_req_valid, rd_req_ready = 1'b0, rd_rsp_valid = 1'b0, rd_rsp_ready;
  logic [ADDR_W-1:0] rd_req_addr;
  logic [63:0] rd_rsp_data = '0;
  logic busy, done, fault_valid, comp_load, comp_init;
  logic [1:0] fault_code;
  logic [IDX_W-1:0] comp_idx;

  always #5 clk = ~clk;

  prs_restore_seq #(.ADDR_W(ADDR_W), .NCOMP(NCOMP)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr_mask(instr_mask),
    .user_en(user_en), .sup_en(sup_en), .priv_lvl(priv_lvl),
    .os_xsave_en(os_xsave_en), .task_sw(task_sw), .feat_xsave(feat_xsave),
    .feat_sup(feat_sup), .pfx_lock(pfx_lock), .pfx_opsz(pfx_opsz),
    .pfx_rep(pfx_rep), .pfx_repne(pfx_repne), .area_addr(area_addr),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data), .busy(busy),
    .done(done), .fault_valid(fault_valid), .fault_code(fault_code),
    .comp_load(comp_load), .comp_init(comp_init), .comp_idx(comp_idx)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model for the header
  logic [63:0] hdr [8];
  logic pend = 1'b0;
  logic [ADDR_W-1:0] paddr = '0, exp_base = '0;
  int nreq = 0, addr_err = 0;
  logic [7:0] lfsr = 8'h5A;
  bit stall_on = 1'b0;

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (rd_req_valid && rd_req_ready) begin
      pend  <= 1'b1;
      paddr <= rd_req_addr;
      if (rd_req_addr != exp_base + ADDR_W'(8 * nreq)) addr_err++;
      nreq++;
    end
    if (rd_rsp_valid && rd_rsp_ready) pend <= 1'b0;
  end

  always @(negedge clk) begin
    rd_req_ready = !pend && (!stall_on || lfsr[0]);
    rd_rsp_valid = pend && (!stall_on || lfsr[1]);
    rd_rsp_data  = hdr[paddr[5:3]];
  end

  // output monitor
  bit mon_on = 1'b0, seen_any = 1'b0;
  int ndone = 0, order_err = 0;
  logic [IDX_W-1:0] last_idx = '0;
  logic [NCOMP-1:0] seen_load = '0, seen_init = '0;
  logic [1:0] got_code = '0;
  logic got_fv = 1'b0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (done) begin
        ndone++;
        got_code = fault_code;
        got_fv   = fault_valid;
      end
      if (comp_load || comp_init) begin
        if (seen_any && comp_idx <= last_idx) order_err++;
        if (comp_load && comp_init) order_err++;
        last_idx = comp_idx;
        seen_any = 1'b1;
        if (comp_load) seen_load[comp_idx] = 1'b1;
        else           seen_init[comp_idx] = 1'b1;
      end
    end
  end

  task automatic set_hdr(input logic [63:0] rst_bm, input logic [63:0] cmp_bm);
    hdr[0] = rst_bm;
    hdr[1] = cmp_bm;
    for (int w = 2; w < 8; w++) hdr[w] = '0;
  endtask

  // ctl: 0 feat_xsave, 1 feat_sup, 2 os_xsave_en, 3 lock, 4 opsz, 5 rep, 6 repne, 7 task_sw
  task automatic run(input logic [63:0] im, input logic [63:0] ue, input logic [63:0] se,
                     input logic [1:0] pl, input logic [ADDR_W-1:0] ad, input logic [7:0] ctl,
                     input bit extra_start, input string tag);
    logic ud, nm, gpp, hgp, tail;
    logic [1:0] ecode;
    logic [63:0] rfbm;
    logic [NCOMP-1:0] eld, ein;
    int t;
    ud   = !ctl[0] || !ctl[1] || !ctl[2] || (|ctl[6:3]);
    nm   = ctl[7];
    gpp  = (pl != 2'd0) || (ad[5:0] != 6'd0);
    tail = |{hdr[2], hdr[3], hdr[4], hdr[5], hdr[6], hdr[7]};
    hgp  = !hdr[1][63] || (|(hdr[1][62:0] & ~ue[62:0])) || (|(hdr[0] & ~hdr[1])) || tail;
    ecode = ud ? 2'd1 : nm ? 2'd2 : gpp ? 2'd3 : hgp ? 2'd3 : 2'd0;
    rfbm = (ue | se) & im;
    eld  = (ecode == 2'd0) ? (rfbm[NCOMP-1:0] &  hdr[0][NCOMP-1:0]) : '0;
    ein  = (ecode == 2'd0) ? (rfbm[NCOMP-1:0] & ~hdr[0][NCOMP-1:0]) : '0;

    @(negedge clk);
    instr_mask = im; user_en = ue; sup_en = se; priv_lvl = pl; area_addr = ad;
    feat_xsave = ctl[0]; feat_sup = ctl[1]; os_xsave_en = ctl[2];
    pfx_lock = ctl[3]; pfx_opsz = ctl[4]; pfx_rep = ctl[5]; pfx_repne = ctl[6]; task_sw = ctl[7];
    exp_base = ad; nreq = 0; addr_err = 0;
    ndone = 0; order_err = 0; seen_any = 1'b0; seen_load = '0; seen_init = '0;
    got_code = 2'd0; got_fv = 1'b0; mon_on = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (extra_start) begin
      repeat (3) @(negedge clk);
      instr_mask = ~im; pfx_lock = 1'b1; task_sw = 1'b1; area_addr = ad + 1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (!done && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 3000, "R11 done timeout", t, 3000);
    @(negedge clk);
    @(negedge clk);
    mon_on = 1'b0;
    chk(got_code == ecode, tag, got_code, ecode);
    chk(got_fv == (ecode != 2'd0), "R11 fault_valid", got_fv, ecode != 2'd0);
    chk(ndone == 1, extra_start ? "R12 done count" : "R11 done count", ndone, 1);
    chk(nreq == ((ud || nm || gpp) ? 0 : 8), "R1 R5 request count", nreq, (ud || nm || gpp) ? 0 : 8);
    chk(addr_err == 0, "R5 request address", addr_err, 0);
    chk(seen_load == eld, extra_start ? "R12 loads" : "R10 loads", seen_load, eld);
    chk(seen_init == ein, "R10 inits", seen_init, ein);
    chk(order_err == 0, "R10 order", order_err, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    string tg;
    logic [63:0] ue;
    set_hdr(64'h0F, 64'h8000_0000_0000_000F);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R11 reset idle", {busy, done}, 0);
    chk(!rd_req_valid && !comp_load && !comp_init, "R1 reset outputs",
        {rd_req_valid, comp_load, comp_init}, 0);

    // sweep of early-fault causes and their priority (R1, R2, R3, R4)
    for (int c = 0; c < 256; c++) begin
      for (int p = 0; p < 2; p++) begin
        for (int m = 0; m < 2; m++) begin
          logic [7:0] cc;
          cc = 8'(c);
          if (!cc[0] || !cc[1] || !cc[2] || (|cc[6:3])) tg = "R2 fault code";
          else if (cc[7]) tg = "R3 fault code";
          else if (p != 0 || m != 0) tg = "R4 fault code";
          else tg = "R10 fault code";
          run(64'hFF, 64'hFF, 64'h0, (p != 0) ? 2'd3 : 2'd0,
              ADDR_W'(48'h1000) + ADDR_W'(m * 8), cc, 1'b0, tg);
        end
      end
    end

    // header bitmap sweep with stalls (R5, R7, R8, R10)
    stall_on = 1'b1;
    for (int u = 0; u < 2; u++) begin
      for (int c = 0; c < 16; c++) begin
        for (int r = 0; r < 16; r++) begin
          ue = (u != 0) ? 64'hF5 : 64'hFF;
          set_hdr(64'(r), 64'h8000_0000_0000_0000 | 64'(c));
          if (|(64'(c) & ~ue)) tg = "R7 fault code";
          else if (|(64'(r) & ~64'(c))) tg = "R8 fault code";
          else tg = "R10 fault code";
          run(64'hFFFF_FFFF_FFFF_FF00 | 64'(8'(c * 13 + r * 7 + u * 5)), ue,
              (r[0] != 0) ? 64'h0C : 64'h0, 2'd0, ADDR_W'(48'h2_0040) + ADDR_W'(c * 64),
              8'h07, 1'b0, tg);
        end
      end
    end

    // compaction format flag clear (R6)
    set_hdr(64'h0, 64'h0F);
    run(64'hFF, 64'hFF, 64'h0, 2'd0, ADDR_W'(48'h3000), 8'h07, 1'b0, "R6 fault code");
    set_hdr(64'h0, 64'h0);
    run(64'hFF, 64'hFF, 64'h0, 2'd0, ADDR_W'(48'h3040), 8'h07, 1'b0, "R6 fault code");

    // non-zero tail words (R9)
    for (int w = 2; w < 8; w++) begin
      set_hdr(64'h03, 64'h8000_0000_0000_0003);
      hdr[w] = 64'h1 << (w * 9);
      run(64'hFF, 64'hFF, 64'h0, 2'd0, ADDR_W'(48'h4000), 8'h07, 1'b0, "R9 fault code");
    end

    // full walk over every component, both enable registers contributing (R10)
    set_hdr(64'hA5, 64'h8000_0000_0000_00FF);
    run(64'hFFFF_FFFF_FFFF_FFFF, 64'hFF, 64'hF00, 2'd0, ADDR_W'(48'h5000), 8'h07, 1'b0, "R10 fault code");
    set_hdr(64'h5A, 64'h8000_0000_0000_00FF);
    run(64'h3C, 64'h0F, 64'hF0, 2'd0, ADDR_W'(48'h5040), 8'h07, 1'b0, "R10 fault code");

    // second start while busy is ignored (R12)
    set_hdr(64'h33, 64'h8000_0000_0000_00FF);
    run(64'hFF, 64'hFF, 64'h0, 2'd0, ADDR_W'(48'h6000), 8'h07, 1'b1, "R12 fault code");
    set_hdr(64'h03, 64'h8000_0000_0000_00FF);
    hdr[5] = 64'h10;
    run(64'hFF, 64'hFF, 64'h0, 2'd0, ADDR_W'(48'h6040), 8'h07, 1'b1, "R12 fault code");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule